// File: doc/BRIEF.md
# Bit-Field Read-Modify-Write Unit

This unit carries out the memory bit operations of a small 8-bit processor over a byte-wide bus. It supports six operations. Two are mask operations: test-and-set and test-and-clear, which use the accumulator as a mask. Two are single-bit operations: set one bit and clear one bit. The last two are branches that test one bit and branch when it is set or when it is clear. The sequencer that feeds the unit has already resolved the effective address. It also supplies the accumulator, the bit index, the address of the next instruction and an 8-bit displacement.

The mask and single-bit operations modify memory in three bus cycles: two reads of the target followed by one write of the new value. A lock output holds off other bus masters from the first read through the write. The branch operations read one zero-page byte and report whether the branch is taken and where it goes. The mask operations report a zero flag, computed from the AND of the mask and the byte as it stood before the write. The unit reports no other flag.

Top module: `bitop_rmw_unit`

## Requirements
- R1: After reset the unit is idle. `busy`, `busRead`, `busWrite`, `memLock`, `done`, `zUpdate` and `brValid` are all low.
- R2: Op code 0 (test-and-set) writes the byte OR the mask back to `effAddr`. It reports Z = 1 exactly when the mask AND the byte read is zero.
- R3: Op code 1 (test-and-clear) writes the byte AND the inverted mask back to `effAddr`. It reports Z in the same way as R2, from the value before modification.
- R4: `zUpdate` pulses in the `done` cycle of op codes 0 and 1 only. Op codes 2 to 5 leave it low. No other flag is produced.
- R5: Each of op codes 0 to 3 makes exactly two reads and then one write, in three consecutive cycles, all to the same address. `done` rises in the cycle after the write.
- R6: `memLock` is high in every bus cycle of op codes 0 to 3. It is low in the cycle after the write and in every bus cycle of a branch.
- R7: Op code 2 sets bit `bitIdx` and op code 3 clears it. Both act on zero-page address {8'h00, effAddr[7:0]} and ignore the upper address byte.
- R8: Op codes 4 and 5 make one read of zero-page byte {8'h00, effAddr[7:0]} and never write. `brValid` pulses with `done`. `brTaken` is set when bit `bitIdx` is 1 for code 4, or 0 for code 5.
- R9: `brTarget` equals `nextPc` plus the sign-extended `disp`, modulo 2^16.
- R10: A `start` that arrives while `busy` is high is ignored. It causes no bus cycle and no memory change.
- R11: Op codes 6 and 7 are not accepted. They cause no bus cycle and no `done`.
- R12: A new operation may start in the `done` cycle of the previous one. The previous results stay valid in that cycle, and the new operation's first read follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin an operation |
| opSel | input | 3 | Operation code (see R2 to R11) |
| bitIdx | input | 3 | Bit number for single-bit operations |
| accMask | input | 8 | Accumulator mask |
| effAddr | input | 16 | Resolved effective address |
| nextPc | input | 16 | Address of the following instruction |
| disp | input | 8 | Signed branch displacement |
| busAddr | output | 16 | Bus address |
| busRead | output | 1 | Read cycle strobe |
| busWrite | output | 1 | Write cycle strobe |
| busWdata | output | 8 | Write data |
| busRdata | input | 8 | Read data, valid during a read cycle |
| memLock | output | 1 | Bus lock for other masters |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| zUpdate | output | 1 | Z flag to be written this cycle |
| zValue | output | 1 | New Z flag value |
| brValid | output | 1 | Branch result valid this cycle |
| brTaken | output | 1 | Branch condition met |
| brTarget | output | 16 | Branch destination |

## Verification
Two events can fall in the same cycle: the completion of one operation, with its result pulse and the lock release, and the acceptance of the next `start`. The bench provokes this by asserting `start` in the very cycle it sees `done`. In that cycle it checks that the earlier Z or branch result is intact and that `memLock` is low. It then checks that the new operation's reads start one cycle later, with the lock held again and the correct address.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [2:0] {
    OP_TSET  = 3'd0,
    OP_TCLR  = 3'd1,
    OP_BSET  = 3'd2,
    OP_BCLR  = 3'd3,
    OP_BRSET = 3'd4,
    OP_BRCLR = 3'd5
  } bitOp_e;

  typedef struct packed {
    logic load;
    logic capture;
    logic finish;
  } ctlStrobe_t;

  function automatic logic isValidOp(input logic [2:0] op);
    return op <= OP_BRCLR;
  endfunction

  function automatic logic isRmwOp(input logic [2:0] op);
    return op <= OP_BCLR;
  endfunction

  function automatic logic isTestOp(input logic [2:0] op);
    return (op == OP_TSET) || (op == OP_TCLR);
  endfunction

  function automatic logic isBranchOp(input logic [2:0] op);
    return (op == OP_BRSET) || (op == OP_BRCLR);
  endfunction
endpackage

// File: rtl/bitop_ctrl.sv
module bitop_ctrl
  import bitop_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] opSel,
  output logic       busy,
  output logic       busRead,
  output logic       busWrite,
  output logic       memLock,
  output logic       done,
  output ctlStrobe_t strobe
);
  typedef enum logic [1:0] {S_IDLE, S_RD1, S_RD2, S_WR} state_e;

  state_e state, nextState;
  logic   rmwQ;
  logic   accept;

  assign accept = start && (state == S_IDLE) && isValidOp(opSel);

  always_comb begin
    nextState = state;
    case (state)
      S_IDLE: if (accept) nextState = S_RD1;
      S_RD1:  nextState = rmwQ ? S_RD2 : S_IDLE;
      S_RD2:  nextState = S_WR;
      S_WR:   nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_comb begin
    strobe.load    = accept;
    strobe.capture = (state == S_RD2);
    strobe.finish  = (state == S_WR) || ((state == S_RD1) && !rmwQ);
  end

  assign busy     = (state != S_IDLE);
  assign busRead  = (state == S_RD1) || (state == S_RD2);
  assign busWrite = (state == S_WR);
  assign memLock  = rmwQ && busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      rmwQ  <= 1'b0;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      done  <= strobe.finish;
      if (accept) rmwQ <= isRmwOp(opSel);
    end
  end

  // R6: the lock is dropped in the cycle right after the write
  a_r6_lock_release: assert property (@(posedge clk) disable iff (!rstN)
    busWrite |=> !memLock);

  // R6: the lock covers the write and both reads before it
  a_r6_lock_span: assert property (@(posedge clk) disable iff (!rstN)
    busWrite |-> memLock && $past(memLock) && $past(memLock, 2));

  // R10: a start refused while busy must not restart the sequence
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strobe.finish) |=> busy);

  // R11: an unsupported code leaves the unit idle
  a_r11_bad_code: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && !isValidOp(opSel)) |=> !busy);
endmodule

// File: rtl/bitop_dpath.sv
module bitop_dpath
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctlStrobe_t                 strobe,
  input  logic [2:0]                 opSel,
  input  logic [$clog2(DATA_W)-1:0]  bitIdx,
  input  logic [DATA_W-1:0]          accMask,
  input  logic [ADDR_W-1:0]          effAddr,
  input  logic [ADDR_W-1:0]          nextPc,
  input  logic [DATA_W-1:0]          disp,
  input  logic [DATA_W-1:0]          busRdata,
  output logic [ADDR_W-1:0]          busAddr,
  output logic [DATA_W-1:0]          busWdata,
  output logic                       zUpdate,
  output logic                       zValue,
  output logic                       brValid,
  output logic                       brTaken,
  output logic [ADDR_W-1:0]          brTarget
);
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int HIGH_W = ADDR_W - DATA_W;

  logic [2:0]        opQ;
  logic [IDX_W-1:0]  bitQ;
  logic [DATA_W-1:0] accQ;
  logic [DATA_W-1:0] rdQ;
  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] targetQ;
  logic [DATA_W-1:0] bitMask;
  logic [ADDR_W-1:0] zpAddr;
  logic [ADDR_W-1:0] sxDisp;

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mask
    assign bitMask[gi] = (bitQ == IDX_W'(gi));
  end

  assign zpAddr = {{HIGH_W{1'b0}}, effAddr[DATA_W-1:0]};
  assign sxDisp = {{HIGH_W{disp[DATA_W-1]}}, disp};

  always_comb begin
    case (opQ)
      OP_TSET: busWdata = rdQ | accQ;
      OP_TCLR: busWdata = rdQ & ~accQ;
      OP_BSET: busWdata = rdQ | bitMask;
      OP_BCLR: busWdata = rdQ & ~bitMask;
      default: busWdata = rdQ;
    endcase
  end

  assign busAddr  = addrQ;
  assign brTarget = targetQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ     <= '0;
      bitQ    <= '0;
      accQ    <= '0;
      rdQ     <= '0;
      addrQ   <= '0;
      targetQ <= '0;
      zUpdate <= 1'b0;
      zValue  <= 1'b0;
      brValid <= 1'b0;
      brTaken <= 1'b0;
    end else begin
      if (strobe.load) begin
        opQ     <= opSel;
        bitQ    <= bitIdx;
        accQ    <= accMask;
        addrQ   <= isTestOp(opSel) ? effAddr : zpAddr;
        targetQ <= nextPc + sxDisp;
      end
      if (strobe.capture) rdQ <= busRdata;
      zUpdate <= strobe.finish && isTestOp(opQ);
      brValid <= strobe.finish && isBranchOp(opQ);
      if (strobe.finish && isTestOp(opQ))
        zValue <= ((accQ & rdQ) == '0);
      if (strobe.finish && isBranchOp(opQ))
        brTaken <= busRdata[bitQ] ^ (opQ == OP_BRCLR);
    end
  end
endmodule

// File: rtl/bitop_rmw_unit.sv
module bitop_rmw_unit
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic [2:0]                opSel,
  input  logic [$clog2(DATA_W)-1:0] bitIdx,
  input  logic [DATA_W-1:0]         accMask,
  input  logic [ADDR_W-1:0]         effAddr,
  input  logic [ADDR_W-1:0]         nextPc,
  input  logic [DATA_W-1:0]         disp,
  output logic [ADDR_W-1:0]         busAddr,
  output logic                      busRead,
  output logic                      busWrite,
  output logic [DATA_W-1:0]         busWdata,
  input  logic [DATA_W-1:0]         busRdata,
  output logic                      memLock,
  output logic                      busy,
  output logic                      done,
  output logic                      zUpdate,
  output logic                      zValue,
  output logic                      brValid,
  output logic                      brTaken,
  output logic [ADDR_W-1:0]         brTarget
);
  ctlStrobe_t strobe;

  bitop_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel),
    .busy(busy), .busRead(busRead), .busWrite(busWrite),
    .memLock(memLock), .done(done), .strobe(strobe)
  );

  bitop_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opSel(opSel),
    .bitIdx(bitIdx), .accMask(accMask), .effAddr(effAddr),
    .nextPc(nextPc), .disp(disp), .busRdata(busRdata),
    .busAddr(busAddr), .busWdata(busWdata), .zUpdate(zUpdate),
    .zValue(zValue), .brValid(brValid), .brTaken(brTaken),
    .brTarget(brTarget)
  );

  // R5: a write follows two reads of the same address
  a_r5_two_reads: assert property (@(posedge clk) disable iff (!rstN)
    busWrite |-> $past(busRead) && $past(busRead, 2)
                 && ($past(busAddr) == busAddr) && ($past(busAddr, 2) == busAddr));

  // R4: a Z report only comes right after a write cycle
  a_r4_z_after_write: assert property (@(posedge clk) disable iff (!rstN)
    zUpdate |-> $past(busWrite) && done);

  // R8: a branch result follows one unlocked read, with no write
  a_r8_branch_read: assert property (@(posedge clk) disable iff (!rstN)
    brValid |-> $past(busRead) && !$past(busRead, 2) && !$past(memLock) && done);

  // R5: the bus never reads and writes at once
  a_r5_bus_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busRead, busWrite}));
endmodule

// File: tb/bitop_rmw_unit_bench.sv
module bitop_rmw_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  opSel = '0;
  logic [2:0]  bitIdx = '0;
  logic [7:0]  accMask = '0;
  logic [15:0] effAddr = '0;
  logic [15:0] nextPc = '0;
  logic [7:0]  disp = '0;
  logic [15:0] busAddr;
  logic        busRead, busWrite, memLock, busy, done;
  logic [7:0]  busWdata, busRdata;
  logic        zUpdate, zValue, brValid, brTaken;
  logic [15:0] brTarget;

  logic [7:0]  mem [0:4095];
  int          vectors = 0, miscompares = 0;
  int          rdCnt = 0, wrCnt = 0, lockBad = 0, addrBad = 0, waitCycles = 0;
  logic        expLock = 1'b0;
  logic [15:0] expAddr = '0;

  always #2 clk = ~clk;

  bitop_rmw_unit u_bitop_rmw_unit (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .bitIdx(bitIdx),
    .accMask(accMask), .effAddr(effAddr), .nextPc(nextPc), .disp(disp),
    .busAddr(busAddr), .busRead(busRead), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .memLock(memLock),
    .busy(busy), .done(done), .zUpdate(zUpdate), .zValue(zValue),
    .brValid(brValid), .brTaken(brTaken), .brTarget(brTarget)
  );

  assign busRdata = mem[busAddr[11:0]];

  always @(posedge clk) begin
    if (busRead) rdCnt = rdCnt + 1;
    if (busWrite) begin
      wrCnt = wrCnt + 1;
      mem[busAddr[11:0]] <= busWdata;
    end
    if (busRead || busWrite) begin
      if (memLock !== expLock) lockBad = lockBad + 1;
      if (busAddr !== expAddr) addrBad = addrBad + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // starts at a negedge, returns at the negedge where done is seen
  task automatic runOp(input logic [2:0] op, input logic [2:0] bi, input logic [7:0] acc,
                       input logic [15:0] ea, input logic [15:0] npc, input logic [7:0] d,
                       input logic lk, input logic [15:0] ad);
    rdCnt = 0; wrCnt = 0; lockBad = 0; addrBad = 0;
    expLock = lk; expAddr = ad;
    start = 1'b1; opSel = op; bitIdx = bi; accMask = acc;
    effAddr = ea; nextPc = npc; disp = d;
    @(negedge clk);
    start = 1'b0;
    waitCycles = 0;
    while (!done && waitCycles < 20) begin
      @(negedge clk);
      waitCycles++;
    end
  endtask

  task automatic tReset;
    check("R1 busy", busy, 0);
    check("R1 bus", {busRead, busWrite, memLock}, 0);
    check("R1 pulses", {done, zUpdate, brValid}, 0);
  endtask

  task automatic tTestSet;
    mem[12'h345] = 8'h5A;
    runOp(3'd0, 3'd0, 8'h81, 16'h0345, 16'h0, 8'h0, 1'b1, 16'h0345);
    check("R2 data", mem[12'h345], 8'h5A | 8'h81);
    check("R2 zero", {zUpdate, zValue}, 2'b11);
    check("R5 reads", rdCnt, 2);
    check("R5 writes", wrCnt, 1);
    check("R5 latency", waitCycles, 3);
    check("R5 address", addrBad, 0);
    check("R6 lock held", lockBad, 0);
    check("R6 lock released", memLock, 0);
    mem[12'h346] = 8'h0F;
    runOp(3'd0, 3'd0, 8'h18, 16'h0346, 16'h0, 8'h0, 1'b1, 16'h0346);
    check("R2 data2", mem[12'h346], 8'h1F);
    check("R2 nonzero", {zUpdate, zValue}, 2'b10);
  endtask

  task automatic tTestClr;
    mem[12'h7F0] = 8'hF0;
    runOp(3'd1, 3'd0, 8'h30, 16'h07F0, 16'h0, 8'h0, 1'b1, 16'h07F0);
    check("R3 data", mem[12'h7F0], 8'hF0 & ~8'h30);
    check("R3 zero", {zUpdate, zValue}, 2'b10);
    check("R4 no branch", brValid, 0);
    check("R6 lock", lockBad, 0);
    mem[12'h7F1] = 8'h0C;
    runOp(3'd1, 3'd0, 8'hC0, 16'h07F1, 16'h0, 8'h0, 1'b1, 16'h07F1);
    check("R3 data2", mem[12'h7F1], 8'h0C);
    check("R3 zero2", {zUpdate, zValue}, 2'b11);
  endtask

  task automatic tBitSetClr;
    mem[12'h042] = 8'h01;
    mem[12'hA42] = 8'h33;
    runOp(3'd2, 3'd7, 8'h00, 16'h3A42, 16'h0, 8'h0, 1'b1, 16'h0042);
    check("R7 set bit7", mem[12'h042], 8'h81);
    check("R7 high byte ignored", mem[12'hA42], 8'h33);
    check("R7 zero page addr", addrBad, 0);
    check("R4 no z", zUpdate, 0);
    check("R5 reads", rdCnt, 2);
    runOp(3'd3, 3'd0, 8'hFF, 16'h5542, 16'h0, 8'h0, 1'b1, 16'h0042);
    check("R7 clear bit0", mem[12'h042], 8'h80);
    check("R4 no z clr", zUpdate, 0);
    check("R6 lock", lockBad, 0);
  endtask

  task automatic tBranch;
    mem[12'h010] = 8'h08;
    runOp(3'd4, 3'd3, 8'h00, 16'h7710, 16'h2000, 8'h10, 1'b0, 16'h0010);
    check("R8 set taken", {brValid, brTaken}, 2'b11);
    check("R9 target fwd", brTarget, 16'h2010);
    check("R8 one read", rdCnt, 1);
    check("R8 no write", wrCnt, 0);
    check("R6 no lock", lockBad, 0);
    check("R4 no z", zUpdate, 0);
    check("R8 mem intact", mem[12'h010], 8'h08);
    runOp(3'd5, 3'd3, 8'h00, 16'h0010, 16'h2000, 8'h10, 1'b0, 16'h0010);
    check("R8 clr not taken", {brValid, brTaken}, 2'b10);
    runOp(3'd4, 3'd1, 8'h00, 16'h0010, 16'h2000, 8'h10, 1'b0, 16'h0010);
    check("R8 set not taken", {brValid, brTaken}, 2'b10);
    runOp(3'd5, 3'd0, 8'h00, 16'h0010, 16'h0005, 8'hF0, 1'b0, 16'h0010);
    check("R8 clr taken", {brValid, brTaken}, 2'b11);
    check("R9 target wrap", brTarget, 16'hFFF5);
  endtask

  task automatic tBusyIgnore;
    mem[12'h200] = 8'h00;
    mem[12'h300] = 8'hFF;
    rdCnt = 0; wrCnt = 0; lockBad = 0; addrBad = 0;
    expLock = 1'b1; expAddr = 16'h0200;
    start = 1'b1; opSel = 3'd0; accMask = 8'h24; effAddr = 16'h0200;
    @(negedge clk);
    opSel = 3'd1; accMask = 8'hFF; effAddr = 16'h0300;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 other addr intact", mem[12'h300], 8'hFF);
    check("R10 first op result", mem[12'h200], 8'h24);
    check("R10 single write", wrCnt, 1);
    check("R10 address", addrBad, 0);
  endtask

  task automatic tBadCode;
    rdCnt = 0; wrCnt = 0;
    start = 1'b1; opSel = 3'd6; effAddr = 16'h0040;
    @(negedge clk);
    opSel = 3'd7;
    @(negedge clk);
    start = 1'b0;
    check("R11 not busy", busy, 0);
    repeat (3) @(negedge clk);
    check("R11 no bus", rdCnt + wrCnt, 0);
    check("R11 no done", done, 0);
  endtask

  task automatic tBackToBack;
    mem[12'h050] = 8'h0A;
    mem[12'h051] = 8'hFF;
    runOp(3'd0, 3'd0, 8'h05, 16'h0050, 16'h0, 8'h0, 1'b1, 16'h0050);
    check("R12 first z", {done, zUpdate, zValue}, 3'b111);
    check("R12 lock low at turn", memLock, 0);
    // start the next op in this done cycle
    runOp(3'd1, 3'd0, 8'h0F, 16'h0051, 16'h0, 8'h0, 1'b1, 16'h0051);
    check("R12 accepted at once", waitCycles, 3);
    check("R12 second data", mem[12'h051], 8'hF0);
    check("R12 second z", {zUpdate, zValue}, 2'b10);
    check("R12 first data", mem[12'h050], 8'h0F);
    check("R12 lock", lockBad, 0);
    check("R12 address", addrBad, 0);
  endtask

  task automatic finishRun;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tTestSet();
    tTestClr();
    tBitSetClr();
    tBranch();
    tBusyIgnore();
    tBadCode();
    tBackToBack();
    @(negedge clk);
    finishRun();
  end
endmodule